// File: doc/BRIEF.md
# Card Interrupt Request Generator

This block combines two general-purpose input pins and the interrupt line of an on-card serial controller into one active-low interrupt request towards the host. Each pin is first synchronized to the block clock. It then passes through a per-pin polarity selector that can keep it, invert it or force it to zero. A per-pin enable bit then gates it. The serial-controller interrupt joins the result through an OR.

The host request runs in one of two modes. In level mode the output follows the combined condition. In pulse mode each new rising edge of the condition produces exactly one low pulse, lasting one period of a programmable clock divider. The block also holds two byte-wide registers on a simple address/data port. One register gives the enable bits and shows the live source states. The other holds two sticky soft-reset bits, one for the serial controller and one for the local bus. The local-bus reset reaches its output only while local-bus mode is selected.

Top module: `card_irq_gen`

## Requirements
- R1: After reset the request output is high (inactive), both pin enables are 0, and both soft-reset outputs are 0.
- R2: Reading offset 0x0C returns bits 7:5 = 0, bit 4 = serial-controller interrupt input, bit 3 = pin 1 enable, bit 2 = pin 0 enable, bit 1 = pin 1 internal state, bit 0 = pin 0 internal state.
- R3: Each pin passes through two synchronizer flops. Its internal state then depends on its 2-bit polarity field: 00 keeps the level, 01 inverts it, and 10 or 11 forces 0. Pin 1 uses polarity bits 3:2 and pin 0 uses bits 1:0.
- R4: A write to 0x0C stores data bit 3 as the pin 1 enable and bit 2 as the pin 0 enable. All other written bits are ignored.
- R5: The condition is the serial-controller interrupt ORed with each pin's internal state ANDed with its enable. In level mode (pulse_mode_i = 0) the request output is low exactly while the condition held at the previous clock edge.
- R6: In pulse mode, a rising edge of the condition yields one low pulse on the request output. The pulse lasts exactly div_ratio_i + 1 clock cycles.
- R7: In pulse mode, no further pulse is issued while the condition stays high. A new pulse follows only after the condition falls and rises again.
- R8: A write to 0x0D stores bit 1 as the serial-controller soft reset and bit 0 as the local-bus soft reset. Bits 7:2 are ignored and read 0. The reset bits stay set until software writes them to 0.
- R9: The local-bus soft-reset output is asserted only while local_bus_mode_i = 1. The stored bit itself stays readable at 0x0D.
- R10: Reads from any offset other than 0x0C and 0x0D return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 2 | Asynchronous user pin inputs |
| uart_irq_i | input | 1 | Serial-controller interrupt, active high |
| pol_cfg_i | input | 4 | Polarity fields: [3:2] pin 1, [1:0] pin 0 |
| pulse_mode_i | input | 1 | 0 = level request, 1 = pulse request |
| div_ratio_i | input | 8 | Pulse divider ratio; period is value + 1 clocks |
| local_bus_mode_i | input | 1 | 1 lets the local-bus soft reset reach its output |
| reg_addr_i | input | 8 | Register offset |
| reg_wr_i | input | 1 | Write strobe, one clock per write |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| irq_n_o | output | 1 | Host interrupt request, active low |
| uart_srst_o | output | 1 | Serial-controller soft reset, active high |
| lbus_srst_o | output | 1 | Local-bus soft reset, active high |

## Verification
In pulse mode, the condition can rise in the same cycle that the divider ticks. That tick may end a pulse already in progress, or start the next one. The bench raises the pin while a long condition is still high and again after a drop. It then counts both the falling edges and the low cycles of the request over a fixed window. Exactly one fall, of div_ratio_i + 1 low cycles, must appear per true rising edge. A register write and a change of the mode input can also land in the same cycle as a live condition. The level-mode vector walk judges that case by reading the status register and the request output together after each change.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int NPINS  = 2;
  localparam int POL_W  = 2;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_SRESET = 8'h0D;

  typedef enum logic [POL_W-1:0] {
    POL_KEEP  = 2'b00,
    POL_INV   = 2'b01,
    POL_OFF_A = 2'b10,
    POL_OFF_B = 2'b11
  } pol_e;

  typedef struct packed {
    logic uart_rst;
    logic lbus_rst;
  } sreset_t;
endpackage

// File: rtl/cirq_rst_sync.sv
module cirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cirq_pin_cond.sv
module cirq_pin_cond
  import card_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic [POL_W-1:0] pol_i,
  output logic             state_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   state_c;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  always_comb begin
    unique case (pol_e'(pol_i))
      POL_KEEP: state_c = sync_q[SYNC_STAGES-1];
      POL_INV:  state_c = ~sync_q[SYNC_STAGES-1];
      default:  state_c = 1'b0;
    endcase
  end

  assign state_o = state_c;
endmodule

// File: rtl/cirq_regs.sv
module cirq_regs
  import card_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NPINS-1:0]  state_i,
  input  logic              uart_irq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NPINS-1:0]  mask_o,
  output sreset_t           srst_o
);
  localparam int MASK_LSB = NPINS;

  logic [NPINS-1:0] mask_q, mask_d;
  sreset_t          srst_q, srst_d;
  logic             wr_status, wr_sreset;

  assign wr_status = wr_i && (addr_i == OFS_STATUS);
  assign wr_sreset = wr_i && (addr_i == OFS_SRESET);

  always_comb begin
    mask_d = mask_q;
    srst_d = srst_q;
    if (wr_status) mask_d = wdata_i[MASK_LSB +: NPINS];
    if (wr_sreset) begin
      srst_d.uart_rst = wdata_i[1];
      srst_d.lbus_rst = wdata_i[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      srst_q <= '0;
    end else begin
      if (wr_status) mask_q <= mask_d;
      if (wr_sreset) srst_q <= srst_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_STATUS) begin
      rdata_o[NPINS-1:0]          = state_i;
      rdata_o[MASK_LSB +: NPINS]  = mask_q;
      rdata_o[2*NPINS]            = uart_irq_i;
    end else if (addr_i == OFS_SRESET) begin
      rdata_o[1] = srst_q.uart_rst;
      rdata_o[0] = srst_q.lbus_rst;
    end
  end

  assign mask_o = mask_q;
  assign srst_o = srst_q;
endmodule

// File: rtl/cirq_req_gen.sv
module cirq_req_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cond_i,
  input  logic             pulse_mode_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             irq_n_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cond_q, lvl_q;
  logic             pend_q, pend_d;
  logic             act_q, act_d;
  logic             tick, rise, start;

  assign tick  = (cnt_q >= div_i);
  assign rise  = cond_i & ~cond_q;
  assign start = tick & pend_q & ~act_q;

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
    if (!pulse_mode_i) begin
      pend_d = 1'b0;
      act_d  = 1'b0;
    end else begin
      pend_d = rise ? 1'b1 : (start ? 1'b0 : pend_q);
      if (start)              act_d = 1'b1;
      else if (tick && act_q) act_d = 1'b0;
      else                    act_d = act_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cond_q <= 1'b0;
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cond_q <= cond_i;
      lvl_q  <= cond_i;
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign irq_n_o = ~(pulse_mode_i ? act_q : lvl_q);
endmodule

// File: rtl/card_irq_gen.sv
module card_irq_gen
  import card_irq_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pin_i,
  input  logic              uart_irq_i,
  input  logic [3:0]        pol_cfg_i,
  input  logic              pulse_mode_i,
  input  logic [DIV_W-1:0]  div_ratio_i,
  input  logic              local_bus_mode_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_n_o,
  output logic              uart_srst_o,
  output logic              lbus_srst_o
);
  logic             rst_n_s;
  logic [NPINS-1:0] state_w;
  logic [NPINS-1:0] mask_w;
  sreset_t          srst_w;
  logic             cond_w;

  cirq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    cirq_pin_cond #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .pin_i   (pin_i[p]),
      .pol_i   (pol_cfg_i[p*POL_W +: POL_W]),
      .state_o (state_w[p])
    );
  end

  cirq_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .addr_i     (reg_addr_i),
    .wr_i       (reg_wr_i),
    .wdata_i    (reg_wdata_i),
    .state_i    (state_w),
    .uart_irq_i (uart_irq_i),
    .rdata_o    (reg_rdata_o),
    .mask_o     (mask_w),
    .srst_o     (srst_w)
  );

  assign cond_w = uart_irq_i | (|(state_w & mask_w));

  cirq_req_gen #(.DIV_W(DIV_W)) u_req (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .cond_i       (cond_w),
    .pulse_mode_i (pulse_mode_i),
    .div_i        (div_ratio_i),
    .irq_n_o      (irq_n_o)
  );

  assign uart_srst_o = srst_w.uart_rst;
  assign lbus_srst_o = srst_w.lbus_rst & local_bus_mode_i;
endmodule

// File: rtl/card_irq_gen_chk.sv
module card_irq_gen_chk
  import card_irq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              cond,
  input logic              uart_irq_i,
  input logic              pulse_mode_i,
  input logic [DIV_W-1:0]  div_ratio_i,
  input logic              local_bus_mode_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_wr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_n_o,
  input logic              uart_srst_o,
  input logic              lbus_srst_o
);
  logic        seen_q;
  logic [15:0] low_len_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      seen_q    <= 1'b0;
      low_len_q <= '0;
    end else begin
      seen_q <= 1'b1;
      if (!irq_n_o && pulse_mode_i) low_len_q <= (low_len_q == 16'hFFFF) ? low_len_q : low_len_q + 1'b1;
      else                          low_len_q <= '0;
    end
  end

  a_r2_status_layout: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_addr_i == OFS_STATUS) |-> (reg_rdata_o[7:5] == 3'b000 && reg_rdata_o[4] == uart_irq_i));

  a_r5_level_follow: assert property (@(posedge clk) disable iff (!rst_n_s)
    (seen_q && !pulse_mode_i && !$past(pulse_mode_i)) |-> (irq_n_o == !$past(cond)));

  a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n_s)
    (seen_q && pulse_mode_i && $past(pulse_mode_i) && $rose(irq_n_o) && $stable(div_ratio_i))
      |-> (low_len_q == 16'(div_ratio_i) + 16'd1));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n_s)
    (seen_q && !$past(reg_wr_i && reg_addr_i == OFS_SRESET)) |-> $stable(uart_srst_o));

  a_r9_lbus_gate: assert property (@(posedge clk) disable iff (!rst_n_s)
    lbus_srst_o |-> local_bus_mode_i);

  a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_addr_i != OFS_STATUS && reg_addr_i != OFS_SRESET) |-> (reg_rdata_o == '0));
endmodule

bind card_irq_gen card_irq_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk              (clk),
  .rst_n_s          (rst_n_s),
  .cond             (cond_w),
  .uart_irq_i       (uart_irq_i),
  .pulse_mode_i     (pulse_mode_i),
  .div_ratio_i      (div_ratio_i),
  .local_bus_mode_i (local_bus_mode_i),
  .reg_addr_i       (reg_addr_i),
  .reg_wr_i         (reg_wr_i),
  .reg_rdata_o      (reg_rdata_o),
  .irq_n_o          (irq_n_o),
  .uart_srst_o      (uart_srst_o),
  .lbus_srst_o      (lbus_srst_o)
);

// File: tb/card_irq_gen_tb_top.sv
module card_irq_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {pol[3:0], mask[1:0], pins[1:0], uart, exp_state[1:0], exp_irq_n}
  localparam logic [11:0] VEC [NVEC] = '{
    12'b0000_00_11_0_11_1,
    12'b0000_01_01_0_01_0,
    12'b0000_10_01_0_01_1,
    12'b0101_11_00_0_11_0,
    12'b0101_11_11_0_00_1,
    12'b1010_11_11_0_00_1,
    12'b1111_11_00_0_00_1,
    12'b0000_00_00_1_00_0,
    12'b0100_10_00_0_10_0,
    12'b0001_01_10_0_11_0
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pin;
  logic       uart_irq;
  logic [3:0] pol;
  logic       pulse_mode;
  logic [7:0] div_ratio;
  logic       lb_mode;
  logic [7:0] addr;
  logic       wr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq_n, uart_srst, lbus_srst;

  int n_run = 0;
  int n_fail = 0;
  int falls, lows;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_irq_gen dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .uart_irq_i(uart_irq),
    .pol_cfg_i(pol), .pulse_mode_i(pulse_mode), .div_ratio_i(div_ratio),
    .local_bus_mode_i(lb_mode), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_n_o(irq_n),
    .uart_srst_o(uart_srst), .lbus_srst_o(lbus_srst)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic watch(input int n);
    logic prev;
    falls = 0; lows = 0;
    prev = irq_n;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!irq_n) lows++;
      if (prev && !irq_n) falls++;
      prev = irq_n;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    rst_n = 1'b0; pin = 2'b00; uart_irq = 1'b0; pol = 4'h0; pulse_mode = 1'b0;
    div_ratio = 8'd3; lb_mode = 1'b0; addr = 8'h00; wr = 1'b0; wdata = 8'h00;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check("R1 irq_n", irq_n, 1);
    check("R1 uart_srst", uart_srst, 0);
    check("R1 lbus_srst", lbus_srst, 0);
    rd_reg(8'h0C, rv); check("R1 status", rv, 8'h00);
    rd_reg(8'h0D, rv); check("R1 sreset", rv, 8'h00);

    // R2 R3 R4 R5 vector walk in level mode
    for (int k = 0; k < NVEC; k++) begin
      pol = VEC[k][11:8];
      pin = VEC[k][5:4];
      uart_irq = VEC[k][3];
      wr_reg(8'h0C, {4'b0000, VEC[k][7:6], 2'b00});
      idle(4);
      rd_reg(8'h0C, rv);
      check("R2_R3 status vec", rv, {3'b000, VEC[k][3], VEC[k][7:6], VEC[k][2:1]});
      check("R5 irq_n vec", irq_n, VEC[k][0]);
    end

    // R3 two-flop delay: raw pin 0 change not visible after one clock
    pol = 4'h0; pin = 2'b00; uart_irq = 1'b0;
    wr_reg(8'h0C, 8'h00); idle(3);
    @(negedge clk); pin = 2'b01;
    @(negedge clk); #1 addr = 8'h0C; #1 check("R3 sync stage1", rdata[0], 0);
    @(negedge clk); #1 check("R3 sync stage2", rdata[0], 1);

    // R4 reserved write bits ignored
    pin = 2'b00;
    wr_reg(8'h0C, 8'hFF); idle(3);
    rd_reg(8'h0C, rv); check("R4 only enables stored", rv, 8'h0C);

    // R10 unmapped offsets
    rd_reg(8'h05, rv); check("R10 unmapped 05", rv, 0);
    rd_reg(8'h0E, rv); check("R10 unmapped 0E", rv, 0);

    // R8 R9 soft resets
    lb_mode = 1'b1;
    wr_reg(8'h0D, 8'hFF);
    rd_reg(8'h0D, rv); check("R8 sreset read", rv, 8'h03);
    check("R8 uart_srst set", uart_srst, 1);
    check("R9 lbus in lb mode", lbus_srst, 1);
    wr_reg(8'h0C, 8'h00); idle(5);
    check("R8 uart_srst sticky", uart_srst, 1);
    wr_reg(8'h0D, 8'h01);
    check("R8 uart_srst cleared", uart_srst, 0);
    lb_mode = 1'b0; #1;
    check("R9 lbus off in normal mode", lbus_srst, 0);
    rd_reg(8'h0D, rv); check("R9 stored bit kept", rv, 8'h01);
    wr_reg(8'h0D, 8'h00);
    lb_mode = 1'b1; #1;
    check("R8 lbus cleared", lbus_srst, 0);

    // R6 R7 pulse mode, div 3
    pulse_mode = 1'b1; div_ratio = 8'd3; pol = 4'h0; pin = 2'b00;
    wr_reg(8'h0C, 8'h04); idle(10);
    check("R6 idle high", irq_n, 1);
    pin = 2'b01;
    watch(40);
    check("R6 one pulse", falls, 1);
    check("R6 width div3", lows, 4);
    watch(40);
    check("R7 no repeat while high", falls, 0);
    pin = 2'b00; idle(10);
    pin = 2'b01;
    watch(40);
    check("R7 new pulse after re-rise", falls, 1);
    check("R7 width div3", lows, 4);

    // R6 div 0 and div 7
    pin = 2'b00; div_ratio = 8'd0; idle(10);
    pin = 2'b01; watch(30);
    check("R6 width div0", lows, 1);
    pin = 2'b00; div_ratio = 8'd7; idle(20);
    pin = 2'b01; watch(60);
    check("R6 one pulse div7", falls, 1);
    check("R6 width div7", lows, 8);

    // R5 uart drives request in pulse mode too, then back to level
    pin = 2'b00; idle(20);
    uart_irq = 1'b1; watch(40);
    check("R5 R6 uart pulse width", lows, 8);
    pulse_mode = 1'b0; idle(2);
    check("R5 level with uart high", irq_n, 0);
    uart_irq = 1'b0; idle(2);
    check("R5 level released", irq_n, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule